// File: doc/BRIEF.md
# Pipeline Hazard Controller

This block supervises an in-order integer pipeline of five stages: fetch, decode, execute, memory and writeback. Each cycle it looks at the source registers of the instruction in decode, the destination, write-enable and load flag of the instruction in execute, and the destination, write-enable and memory-access flag of the instruction in memory. It also sees the fetch request and the branch outcome, which is settled in decode. From these inputs it steers the datapath. It drives operand bypass selects for the execute stage, holds the program counter and the fetch/decode register, squashes the fetch/decode register into a bubble, injects a bubble into execute and redirects fetch to a branch target.

Fetch always continues at the sequential address. When a branch in decode resolves taken, the younger instruction already fetched is squashed and fetch is redirected to the target, which costs one cycle. A not-taken branch costs nothing. A load followed at once by a consumer of its result holds that consumer in decode for one cycle. Fetch loses the single memory port to a data access in the memory stage. The bypass selects are worked out while the consumer is still in decode and are registered, so they are valid during the cycle the consumer spends in execute. All stall, squash and redirect outputs are combinational from the current stage contents.

Top module: `hz_ctrl`

## Requirements
- R1: After reset both operand selects read 0 (register-file value). With all inputs idle, pc_hold, fd_hold, fd_squash, ex_bubble and pc_redirect are low.
- R2: A decode source that is enabled, non-zero and equal to the destination of a writing instruction in execute makes that operand's select read 1 (memory-stage result) in the next cycle.
- R3: A decode source that matches only a writing, non-zero destination in the memory stage makes that operand's select read 2 (writeback-stage result) in the next cycle.
- R4: When both the execute and the memory stage hold a matching destination, select 1 (the younger result) is chosen.
- R5: A destination of register 0, or a producer with write-enable low, never causes forwarding or a stall.
- R6: A load in execute whose destination matches an enabled source in decode raises fd_hold, pc_hold and ex_bubble for that cycle, with fd_squash low. The next cycle both selects read 0, and once the load has reached memory the consumer passes with select 2.
- R7: A memory access in the memory stage together with a fetch request raises pc_hold and fd_squash, while fd_hold and ex_bubble stay low.
- R8: A branch in decode that resolves not-taken raises neither pc_redirect nor fd_squash.
- R9: A taken branch in decode raises pc_redirect and fd_squash with pc_hold low.
- R10: A taken branch held by a load-use stall raises neither pc_redirect nor fd_squash. The redirect follows in the first cycle the stall is gone.
- R11: A taken branch coinciding with a memory-port clash raises pc_redirect and fd_squash with pc_hold low.
- R12: A source whose enable is low neither forwards nor stalls, even when its register number matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_req | input | 1 | Fetch wants the memory port this cycle |
| id_rs1 | input | AW | First source register of decode instruction |
| id_rs1_en | input | 1 | First source is read |
| id_rs2 | input | AW | Second source register of decode instruction |
| id_rs2_en | input | 1 | Second source is read |
| id_branch | input | 1 | Decode holds a conditional branch |
| id_taken | input | 1 | Branch condition resolved taken |
| ex_rd | input | AW | Destination of execute instruction |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | AW | Destination of memory-stage instruction |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_access | input | 1 | Memory-stage instruction uses the memory port |
| fwd_a | output | 2 | Execute operand A select (0 regfile, 1 memory stage, 2 writeback) |
| fwd_b | output | 2 | Execute operand B select, same encoding |
| pc_hold | output | 1 | Keep the program counter |
| pc_redirect | output | 1 | Load the branch target into the program counter |
| fd_hold | output | 1 | Keep the fetch/decode register |
| fd_squash | output | 1 | Load a bubble into the fetch/decode register |
| ex_bubble | output | 1 | Load a bubble into the decode/execute register |

## Verification
Two pairs of functions can fall in one cycle. The first is a taken branch in decode together with a load-use interlock on that same branch. The second is a taken branch together with a memory-port clash between a data access and fetch. The first pair is provoked by giving the branch a source equal to the destination of a load in execute. The correct result is a pure stall with no redirect, followed one cycle later by the redirect. The second pair is provoked by asserting a memory access and a fetch request beside the taken branch, and it is judged by a redirect with squash and no program-counter hold.

// File: rtl/hzc_pkg.sv
package hzc_pkg;

    // Number of register sources an instruction can read.
    localparam int unsigned SRC_CNT = 2;

    // Execute operand source select.
    typedef enum logic [1:0] {
        FWD_REG = 2'd0,
        FWD_MEM = 2'd1,
        FWD_WB  = 2'd2
    } fwd_sel_e;

    // Registered controller state: one select per source operand.
    typedef struct packed {
        fwd_sel_e [SRC_CNT-1:0] sel;
    } hz_state_t;

endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
    parameter int unsigned AW = 5
) (
    input  logic [AW-1:0] src_i,
    input  logic          src_en_i,
    input  logic [AW-1:0] ex_rd_i,
    input  logic          ex_we_i,
    input  logic [AW-1:0] mem_rd_i,
    input  logic          mem_we_i,
    output logic          hit_ex_o,
    output logic          hit_mem_o
);

    logic ex_live;
    logic mem_live;

    // A producer counts only if it writes a register other than zero.
    assign ex_live  = ex_we_i  && (ex_rd_i  != '0);
    assign mem_live = mem_we_i && (mem_rd_i != '0);

    assign hit_ex_o  = src_en_i && ex_live  && (ex_rd_i  == src_i);
    assign hit_mem_o = src_en_i && mem_live && (mem_rd_i == src_i);

endmodule

// File: rtl/hz_stall_arb.sv
module hz_stall_arb (
    input  logic load_dep_i,
    input  logic port_clash_i,
    input  logic br_taken_i,
    output logic pc_hold_o,
    output logic pc_redirect_o,
    output logic fd_hold_o,
    output logic fd_squash_o,
    output logic ex_bubble_o
);

    logic redirect;

    always_comb begin
        // An interlocked branch stays in decode; its redirect waits.
        redirect      = br_taken_i && !load_dep_i;
        pc_redirect_o = redirect;
        fd_hold_o     = load_dep_i;
        ex_bubble_o   = load_dep_i;
        // Redirect replaces the program counter, so no hold is needed then.
        pc_hold_o     = load_dep_i || (port_clash_i && !redirect);
        // A hold keeps the decode instruction; otherwise a lost fetch or a
        // wrong-path fetch becomes a bubble.
        fd_squash_o   = !load_dep_i && (redirect || port_clash_i);
    end

endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
    import hzc_pkg::*;
#(
    parameter int unsigned AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          if_req,
    input  logic [AW-1:0] id_rs1,
    input  logic          id_rs1_en,
    input  logic [AW-1:0] id_rs2,
    input  logic          id_rs2_en,
    input  logic          id_branch,
    input  logic          id_taken,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_we,
    input  logic          ex_load,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_we,
    input  logic          mem_access,
    output logic [1:0]    fwd_a,
    output logic [1:0]    fwd_b,
    output logic          pc_hold,
    output logic          pc_redirect,
    output logic          fd_hold,
    output logic          fd_squash,
    output logic          ex_bubble
);

    logic [SRC_CNT-1:0][AW-1:0] src;
    logic [SRC_CNT-1:0]         src_en;
    logic [SRC_CNT-1:0]         hit_ex;
    logic [SRC_CNT-1:0]         hit_mem;
    logic                       load_dep;

    hz_state_t st_d;
    hz_state_t st_q;

    assign src    = {id_rs2, id_rs1};
    assign src_en = {id_rs2_en, id_rs1_en};

    for (genvar i = 0; i < SRC_CNT; i++) begin : g_src
        hz_src_match #(.AW(AW)) u_match (
            .src_i    (src[i]),
            .src_en_i (src_en[i]),
            .ex_rd_i  (ex_rd),
            .ex_we_i  (ex_we),
            .mem_rd_i (mem_rd),
            .mem_we_i (mem_we),
            .hit_ex_o (hit_ex[i]),
            .hit_mem_o(hit_mem[i])
        );
    end

    // A load result is not ready for a consumer one stage behind it.
    assign load_dep = ex_load && (|hit_ex);

    hz_stall_arb u_arb (
        .load_dep_i   (load_dep),
        .port_clash_i (mem_access && if_req),
        .br_taken_i   (id_branch && id_taken),
        .pc_hold_o    (pc_hold),
        .pc_redirect_o(pc_redirect),
        .fd_hold_o    (fd_hold),
        .fd_squash_o  (fd_squash),
        .ex_bubble_o  (ex_bubble)
    );

    // Selects are computed in decode: the execute producer moves to memory
    // and the memory producer moves to writeback at the same edge.
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < SRC_CNT; i++) begin
            if (ex_bubble) begin
                st_d.sel[i] = FWD_REG;
            end else if (hit_ex[i]) begin
                st_d.sel[i] = FWD_MEM;
            end else if (hit_mem[i]) begin
                st_d.sel[i] = FWD_WB;
            end else begin
                st_d.sel[i] = FWD_REG;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fwd_a = st_q.sel[0];
    assign fwd_b = st_q.sel[1];

endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk #(
    parameter int unsigned AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          if_req,
    input logic [AW-1:0] id_rs1,
    input logic          id_rs1_en,
    input logic [AW-1:0] id_rs2,
    input logic          id_rs2_en,
    input logic          id_branch,
    input logic          id_taken,
    input logic [AW-1:0] ex_rd,
    input logic          ex_we,
    input logic          ex_load,
    input logic [AW-1:0] mem_rd,
    input logic          mem_we,
    input logic          mem_access,
    input logic [1:0]    fwd_a,
    input logic [1:0]    fwd_b,
    input logic          pc_hold,
    input logic          pc_redirect,
    input logic          fd_hold,
    input logic          fd_squash,
    input logic          ex_bubble
);

    assert_fwd_mem_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rs1_en && ex_we && ex_rd != '0 && id_rs1 == ex_rd && !ex_bubble)
        |=> (fwd_a == 2'd1));

    assert_fwd_wb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rs2_en && mem_we && mem_rd != '0 && id_rs2 == mem_rd
         && !(ex_we && ex_rd == id_rs2) && !ex_bubble)
        |=> (fwd_b == 2'd2));

    assert_zero_reg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rd == '0 && mem_rd == '0) |-> !fd_hold);

    assert_stall_group_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fd_hold |-> (ex_bubble && pc_hold && !fd_squash));

    assert_bubble_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ex_bubble |=> (fwd_a == 2'd0 && fwd_b == 2'd0));

    assert_port_clash_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_access && if_req && !fd_hold) |-> fd_squash);

    assert_redirect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pc_redirect |-> (fd_squash && !pc_hold));

    assert_stall_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fd_hold |-> !pc_redirect);

    assert_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (id_branch && id_taken && !fd_hold) |-> pc_redirect);

endmodule

bind hz_ctrl hz_ctrl_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_hz_ctrl.sv
`timescale 1ns/1ps
module tb_hz_ctrl;

    localparam int unsigned AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          if_req, id_rs1_en, id_rs2_en, id_branch, id_taken;
    logic [AW-1:0] id_rs1, id_rs2, ex_rd, mem_rd;
    logic          ex_we, ex_load, mem_we, mem_access;
    logic [1:0]    fwd_a, fwd_b;
    logic          pc_hold, pc_redirect, fd_hold, fd_squash, ex_bubble;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    hz_ctrl #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .if_req(if_req),
        .id_rs1(id_rs1), .id_rs1_en(id_rs1_en),
        .id_rs2(id_rs2), .id_rs2_en(id_rs2_en),
        .id_branch(id_branch), .id_taken(id_taken),
        .ex_rd(ex_rd), .ex_we(ex_we), .ex_load(ex_load),
        .mem_rd(mem_rd), .mem_we(mem_we), .mem_access(mem_access),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .pc_hold(pc_hold),
        .pc_redirect(pc_redirect), .fd_hold(fd_hold),
        .fd_squash(fd_squash), .ex_bubble(ex_bubble)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle();
        if_req = 0; id_rs1 = '0; id_rs1_en = 0; id_rs2 = '0; id_rs2_en = 0;
        id_branch = 0; id_taken = 0; ex_rd = '0; ex_we = 0; ex_load = 0;
        mem_rd = '0; mem_we = 0; mem_access = 0;
    endtask

    // Settle combinational outputs, sampled mid-cycle.
    task automatic settle();
        #1;
    endtask

    // Pass the clock edge and move away from it.
    task automatic edge_step();
        @(posedge clk);
        #1;
    endtask

    // Check every control output against one expected set.
    task automatic ctl(input string req, input bit ph, input bit rd,
                       input bit fh, input bit fs, input bit eb);
        chk({req, " pc_hold"}, int'(pc_hold), int'(ph));
        chk({req, " pc_redirect"}, int'(pc_redirect), int'(rd));
        chk({req, " fd_hold"}, int'(fd_hold), int'(fh));
        chk({req, " fd_squash"}, int'(fd_squash), int'(fs));
        chk({req, " ex_bubble"}, int'(ex_bubble), int'(eb));
    endtask

    task automatic t_reset();
        idle(); settle();
        chk("R1 fwd_a", int'(fwd_a), 0);
        chk("R1 fwd_b", int'(fwd_b), 0);
        ctl("R1", 0, 0, 0, 0, 0);
    endtask

    task automatic t_ex_forward();
        idle(); ex_rd = 5'd3; ex_we = 1; id_rs1 = 5'd3; id_rs1_en = 1;
        id_rs2 = 5'd8; id_rs2_en = 1; settle();
        ctl("R2", 0, 0, 0, 0, 0);
        edge_step();
        chk("R2 fwd_a", int'(fwd_a), 1);
        chk("R2 fwd_b", int'(fwd_b), 0);
    endtask

    task automatic t_wb_forward();
        idle(); mem_rd = 5'd3; mem_we = 1; id_rs2 = 5'd3; id_rs2_en = 1;
        id_rs1 = 5'd6; id_rs1_en = 1; edge_step();
        chk("R3 fwd_b", int'(fwd_b), 2);
        chk("R3 fwd_a", int'(fwd_a), 0);
    endtask

    task automatic t_priority();
        idle(); ex_rd = 5'd4; ex_we = 1; mem_rd = 5'd4; mem_we = 1;
        id_rs1 = 5'd4; id_rs1_en = 1; id_rs2 = 5'd4; id_rs2_en = 1;
        edge_step();
        chk("R4 fwd_a", int'(fwd_a), 1);
        chk("R4 fwd_b", int'(fwd_b), 1);
    endtask

    task automatic t_zero_reg();
        idle(); ex_rd = 5'd0; ex_we = 1; ex_load = 1; mem_rd = 5'd0; mem_we = 1;
        id_rs1 = 5'd0; id_rs1_en = 1; settle();
        ctl("R5 r0", 0, 0, 0, 0, 0);
        edge_step();
        chk("R5 r0 fwd_a", int'(fwd_a), 0);
        idle(); ex_rd = 5'd5; ex_we = 0; ex_load = 1; mem_rd = 5'd5; mem_we = 0;
        id_rs1 = 5'd5; id_rs1_en = 1; settle();
        ctl("R5 we_low", 0, 0, 0, 0, 0);
        edge_step();
        chk("R5 we_low fwd_a", int'(fwd_a), 0);
    endtask

    task automatic t_load_use();
        int stalls = 0;
        idle(); ex_rd = 5'd7; ex_we = 1; ex_load = 1; id_rs2 = 5'd7; id_rs2_en = 1;
        settle();
        ctl("R6 stall", 1, 0, 1, 0, 1);
        if (fd_hold) stalls++;
        edge_step();
        chk("R6 bubble fwd_b", int'(fwd_b), 0);
        // Load now in memory, bubble in execute, consumer still in decode.
        idle(); mem_rd = 5'd7; mem_we = 1; mem_access = 1; id_rs2 = 5'd7;
        id_rs2_en = 1; settle();
        ctl("R6 release", 0, 0, 0, 0, 0);
        if (fd_hold) stalls++;
        chk("R6 stall count", stalls, 1);
        edge_step();
        chk("R6 fwd_b after", int'(fwd_b), 2);
    endtask

    task automatic t_src_disabled();
        idle(); ex_rd = 5'd7; ex_we = 1; ex_load = 1; id_rs1 = 5'd7;
        id_rs1_en = 0; id_rs2 = 5'd7; id_rs2_en = 0; settle();
        ctl("R12", 0, 0, 0, 0, 0);
        edge_step();
        chk("R12 fwd_a", int'(fwd_a), 0);
        chk("R12 fwd_b", int'(fwd_b), 0);
    endtask

    task automatic t_port_clash();
        idle(); mem_access = 1; if_req = 1; settle();
        ctl("R7 clash", 1, 0, 0, 1, 0);
        idle(); mem_access = 1; if_req = 0; settle();
        ctl("R7 no_fetch", 0, 0, 0, 0, 0);
        edge_step();
    endtask

    task automatic t_not_taken();
        idle(); id_branch = 1; id_taken = 0; if_req = 1; settle();
        ctl("R8", 0, 0, 0, 0, 0);
        edge_step();
    endtask

    task automatic t_taken();
        idle(); id_branch = 1; id_taken = 1; if_req = 1; settle();
        ctl("R9", 0, 1, 0, 1, 0);
        edge_step();
    endtask

    task automatic t_taken_load_use();
        idle(); id_branch = 1; id_taken = 1; id_rs1 = 5'd9; id_rs1_en = 1;
        ex_rd = 5'd9; ex_we = 1; ex_load = 1; settle();
        ctl("R10 held", 1, 0, 1, 0, 1);
        edge_step();
        idle(); id_branch = 1; id_taken = 1; id_rs1 = 5'd9; id_rs1_en = 1;
        mem_rd = 5'd9; mem_we = 1; settle();
        ctl("R10 redirect", 0, 1, 0, 1, 0);
        edge_step();
    endtask

    task automatic t_taken_clash();
        idle(); id_branch = 1; id_taken = 1; mem_access = 1; if_req = 1;
        settle();
        ctl("R11", 0, 1, 0, 1, 0);
        edge_step();
    endtask

    initial begin
        idle();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_ex_forward();
        t_wb_forward();
        t_priority();
        t_zero_reg();
        t_load_use();
        t_src_disabled();
        t_port_clash();
        t_not_taken();
        t_taken();
        t_taken_load_use();
        t_taken_clash();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule